// File: doc/BRIEF.md
# Fractional Serial Bit Clock Generator

This block produces the serial clock and the launch and capture strobes for an SPI-style serial controller. A transaction starts with a one-cycle start pulse. At that point the block samples the device select, the 8-bit rate field, clock polarity and clock phase of the selected device, the lane mode and the byte count of the transaction. It then holds these values until the transaction ends.

The rate is not set by an integer divider. A 9-bit phase accumulator adds the rate field on every input clock. A rise of the accumulator's top bit marks the first SCK edge of a bit, and a carry out of the accumulator marks the second edge. The serial bit rate is therefore the input clock times the field divided by 512. Because the field is restricted to powers of two, the bit period is always a whole number of input clocks. The block counts completed bits into bytes according to the lane width. It pulses once per finished byte, and once more with a completion pulse when the programmed byte count is reached. The data shifter and the chip-select logic use the strobes, and the byte count is exposed for them.

Top module: `spi_bitclk_gen`

## Requirements
- R1: After reset, and whenever no transaction runs, busy_o, launch_o, capture_o, byte_done_o and all_done_o are low. sck_o equals the polarity bit of the currently selected device. byte_count_o reads 0 after reset.
- R2: With effective rate field F, the first SCK edge of each bit comes 256/F input clocks after the start of that bit, and the second edge comes 512/F clocks after it. The first bit starts at the clock edge that accepts start_i. F = 128 gives a bit every 4 clocks; F = 1 gives a bit every 512 clocks.
- R3: A rate field of zero, or one that is not a power of two, runs as if it were 1.
- R4: sck_o rests at the latched polarity, moves to the opposite level on the first edge of every bit, and returns on the second edge.
- R5: With phase 0, capture_o pulses on the first edge of each bit. launch_o pulses in the cycle after start and on the second edge of every bit except the last bit of the transaction. With phase 1, launch_o pulses on the first edge and capture_o on the second. launch_o and capture_o are never high together.
- R6: Lane mode code 0 gives 8 bits per byte, code 1 gives 4, code 2 gives 2, and code 3 is treated as code 0.
- R7: On the second edge of the last bit of each byte, byte_done_o pulses for one cycle and byte_count_o increases by one. byte_count_o is cleared when a transaction is accepted.
- R8: On the final byte, all_done_o pulses for one cycle and busy_o falls in the same cycle. A start with byte count 0 gives an all_done_o pulse in the next cycle with no strobes and no SCK activity.
- R9: While busy_o is high, start_i has no effect, and changes to the rate fields and the lane mode have no effect on the running transaction.
- R10: Each of the NUM_DEV device selects has its own rate field, polarity and phase, and dev_sel_i picks which one a transaction uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dev_sel_i | input | SEL_W | Device select index |
| rate_fields_i | input | NUM_DEV*8 | Rate field per device; device d uses bits [8d+7:8d] |
| cpol_i | input | NUM_DEV | Clock polarity per device |
| cpha_i | input | NUM_DEV | Clock phase per device |
| lane_mode_i | input | 2 | 0 single, 1 dual, 2 quad, 3 as single |
| xfer_bytes_i | input | CNT_W | Byte count of the transaction |
| sck_o | output | 1 | Serial clock |
| launch_o | output | 1 | Strobe: drive the next data bit |
| capture_o | output | 1 | Strobe: sample the incoming data bit |
| byte_done_o | output | 1 | One-cycle pulse per completed byte |
| all_done_o | output | 1 | One-cycle pulse at transaction end |
| busy_o | output | 1 | Transaction in progress |
| byte_count_o | output | CNT_W | Bytes completed in this transaction |

## Verification
The bench uses the default build: eight device selects and a 16-bit byte counter. This means every select index, all eight rate field values and every lane code can be reached. Transactions are kept to a few bytes so that even the slowest rate (512 clocks per bit) fits in the run. The byte-count-zero case and the suppressed launch on the last bit are reached directly. The wide counter field itself is reached only at its low end.

// File: rtl/spi_bitclk_pkg.sv
package spi_bitclk_pkg;

  localparam int unsigned RATE_W = 8;
  localparam int unsigned ACC_W  = RATE_W + 1;

  typedef enum logic [1:0] {
    LANE_X1   = 2'd0,
    LANE_X2   = 2'd1,
    LANE_X4   = 2'd2,
    LANE_RSVD = 2'd3
  } lane_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              cpol;
    logic              cpha;
  } dev_cfg_t;

  function automatic logic [3:0] bits_per_byte(lane_e mode);
    case (mode)
      LANE_X2: return 4'd4;
      LANE_X4: return 4'd2;
      default: return 4'd8;
    endcase
  endfunction

  // zero or non-power-of-two fields fall back to the slowest step
  function automatic logic [RATE_W-1:0] fix_rate(logic [RATE_W-1:0] f);
    if (f == '0 || (f & (f - RATE_W'(1))) != '0) return RATE_W'(1);
    return f;
  endfunction

endpackage

// File: rtl/spi_bitclk_cfg_sel.sv
module spi_bitclk_cfg_sel
  import spi_bitclk_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [NUM_DEV*RATE_W-1:0] rates_i,
  input  logic [NUM_DEV-1:0]        cpol_i,
  input  logic [NUM_DEV-1:0]        cpha_i,
  output dev_cfg_t                  cfg_o
);

  dev_cfg_t per_dev [NUM_DEV];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign per_dev[g].rate = fix_rate(rates_i[g*RATE_W +: RATE_W]);
    assign per_dev[g].cpol = cpol_i[g];
    assign per_dev[g].cpha = cpha_i[g];
  end

  always_comb begin
    cfg_o = '{rate: RATE_W'(1), cpol: 1'b0, cpha: 1'b0};
    for (int i = 0; i < NUM_DEV; i++) begin
      if (sel_i == SEL_W'(i)) cfg_o = per_dev[i];
    end
  end

endmodule

// File: rtl/spi_bitclk_phase_acc.sv
module spi_bitclk_phase_acc
  import spi_bitclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              lead_o,
  output logic              trail_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + (ACC_W+1)'(rate_i);

  // top bit rising = first edge of a bit, carry = second edge
  assign lead_o  = run_i & sum[ACC_W-1] & ~acc_q[ACC_W-1] & ~sum[ACC_W];
  assign trail_o = run_i & sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (run_i)   acc_q <= sum[ACC_W-1:0];
  end

endmodule

// File: rtl/spi_bitclk_byte_ctr.sv
module spi_bitclk_byte_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             trail_i,
  input  logic [3:0]       bpb_i,
  output logic             last_bit_o,
  output logic [CNT_W-1:0] count_o
);

  logic [3:0] bit_q;

  assign last_bit_o = (bit_q == bpb_i - 4'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= '0;
      count_o <= '0;
    end else if (load_i) begin
      bit_q   <= '0;
      count_o <= '0;
    end else if (trail_i) begin
      if (last_bit_o) begin
        bit_q   <= '0;
        count_o <= count_o + CNT_W'(1);
      end else begin
        bit_q   <= bit_q + 4'd1;
      end
    end
  end

endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen
  import spi_bitclk_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [SEL_W-1:0]          dev_sel_i,
  input  logic [NUM_DEV*RATE_W-1:0] rate_fields_i,
  input  logic [NUM_DEV-1:0]        cpol_i,
  input  logic [NUM_DEV-1:0]        cpha_i,
  input  logic [1:0]                lane_mode_i,
  input  logic [CNT_W-1:0]          xfer_bytes_i,
  output logic                      sck_o,
  output logic                      launch_o,
  output logic                      capture_o,
  output logic                      byte_done_o,
  output logic                      all_done_o,
  output logic                      busy_o,
  output logic [CNT_W-1:0]          byte_count_o
);

  dev_cfg_t          sel_cfg;
  logic              busy_q, sck_q, cpol_q, cpha_q;
  logic              launch_q, capture_q, bdone_q, adone_q;
  logic [RATE_W-1:0] rate_q;
  logic [3:0]        bpb_q;
  logic [CNT_W-1:0]  size_q;
  logic [CNT_W-1:0]  count;
  logic              start_acc, zero_size, lead, trail, last_bit;
  logic              byte_end, final_byte;

  spi_bitclk_cfg_sel #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_sel (
    .sel_i   (dev_sel_i),
    .rates_i (rate_fields_i),
    .cpol_i  (cpol_i),
    .cpha_i  (cpha_i),
    .cfg_o   (sel_cfg)
  );

  spi_bitclk_phase_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_acc),
    .run_i   (busy_q),
    .rate_i  (rate_q),
    .lead_o  (lead),
    .trail_o (trail)
  );

  spi_bitclk_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_acc),
    .trail_i    (trail),
    .bpb_i      (bpb_q),
    .last_bit_o (last_bit),
    .count_o    (count)
  );

  assign start_acc  = start_i & ~busy_q;
  assign zero_size  = (xfer_bytes_i == '0);
  assign byte_end   = trail & last_bit;
  assign final_byte = byte_end & ((count + CNT_W'(1)) == size_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rate_q <= RATE_W'(1);
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      bpb_q  <= 4'd8;
      size_q <= '0;
    end else if (start_acc) begin
      busy_q <= ~zero_size;
      rate_q <= sel_cfg.rate;
      cpol_q <= sel_cfg.cpol;
      cpha_q <= sel_cfg.cpha;
      bpb_q  <= bits_per_byte(lane_e'(lane_mode_i));
      size_q <= xfer_bytes_i;
    end else if (final_byte) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
      bdone_q   <= 1'b0;
      adone_q   <= 1'b0;
    end else begin
      if (start_acc)  sck_q <= sel_cfg.cpol;
      else if (lead)  sck_q <= ~cpol_q;
      else if (trail) sck_q <= cpol_q;
      // phase 0 needs the first bit driven before the first edge
      launch_q  <= (start_acc & ~zero_size & ~sel_cfg.cpha) |
                   (cpha_q ? lead : (trail & ~final_byte));
      capture_q <= cpha_q ? trail : lead;
      bdone_q   <= byte_end;
      adone_q   <= final_byte | (start_acc & zero_size);
    end
  end

  assign sck_o        = busy_q ? sck_q : sel_cfg.cpol;
  assign launch_o     = launch_q;
  assign capture_o    = capture_q;
  assign byte_done_o  = bdone_q;
  assign all_done_o   = adone_q;
  assign busy_o       = busy_q;
  assign byte_count_o = count;

endmodule

// File: rtl/spi_bitclk_gen_chk.sv
module spi_bitclk_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sck_o,
  input logic             launch_o,
  input logic             capture_o,
  input logic             byte_done_o,
  input logic             all_done_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] byte_count_o
);

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && capture_o)); // R5

  AST_CAPTURE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> (sck_o != $past(sck_o))); // R4

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_done_o |-> !busy_o); // R8

  AST_BYTE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> (byte_count_o == $past(byte_count_o) + CNT_W'(1))); // R7

  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (byte_count_o == $past(byte_count_o) ||
                byte_count_o == $past(byte_count_o) + CNT_W'(1))); // R9

endmodule

bind spi_bitclk_gen spi_bitclk_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/spi_bitclk_gen_test.sv
`timescale 1ns/1ps
module spi_bitclk_gen_test;

  localparam int ND = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  sel = '0;
  logic [63:0] rates = '0;
  logic [7:0]  cpol = '0;
  logic [7:0]  cpha = '0;
  logic [1:0]  lane = '0;
  logic [15:0] nbytes = '0;
  logic        sck, launch, capture, bdone, adone, busy;
  logic [15:0] bcount;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_bitclk_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_sel_i(sel),
    .rate_fields_i(rates), .cpol_i(cpol), .cpha_i(cpha),
    .lane_mode_i(lane), .xfer_bytes_i(nbytes),
    .sck_o(sck), .launch_o(launch), .capture_o(capture),
    .byte_done_o(bdone), .all_done_o(adone), .busy_o(busy),
    .byte_count_o(bcount)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_rate(input int f);
    if (f == 0 || (f & (f - 1)) != 0) return 1;
    return f;
  endfunction

  function automatic int bpb(input int m);
    if (m == 1) return 4;
    if (m == 2) return 2;
    return 8;
  endfunction

  // run one transaction and compare every cycle with the model;
  // at cycle disturb_k a restart and new rate/lane are driven (R9)
  task automatic run_xfer(input string req, input int s, input int field,
                          input int mode, input int size, input int disturb_k);
    int h, blen, t;
    bit pol, pha;
    h    = 256 / eff_rate(field);
    blen = bpb(mode) * 2 * h;
    t    = size * blen;
    pol  = cpol[s];
    pha  = cpha[s];
    @(negedge clk);
    sel = 3'(s);
    rates[s*8 +: 8] = 8'(field);
    lane = 2'(mode);
    nbytes = 16'(size);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= t; k++) begin
      bit ph, lead_e, trail_e, sck_e, launch_e, cap_e, bd_e;
      ph      = (k > 0) && (k % h == 0);
      lead_e  = ph && ((k / h) % 2 == 1);
      trail_e = ph && ((k / h) % 2 == 0);
      sck_e   = (k >= t) ? pol : (pol ^ bit'((k / h) % 2));
      launch_e = (k == 0 && t > 0 && !pha) ||
                 (pha ? lead_e : (trail_e && k < t));
      cap_e   = pha ? trail_e : lead_e;
      bd_e    = trail_e && (k % blen == 0);
      chk(sck == sck_e, {req, " R4"}, $sformatf("sck k=%0d", k), sck, sck_e);
      chk(launch == launch_e, {req, " R5"}, $sformatf("launch k=%0d", k), launch, launch_e);
      chk(capture == cap_e, {req, " R5"}, $sformatf("capture k=%0d", k), capture, cap_e);
      chk(bdone == bd_e, {req, " R7"}, $sformatf("byte_done k=%0d", k), bdone, bd_e);
      chk(bcount == 16'(k / blen), {req, " R7"}, $sformatf("count k=%0d", k), bcount, k / blen);
      chk(busy == (k < t), {req, " R8"}, $sformatf("busy k=%0d", k), busy, k < t);
      chk(adone == (k == t), {req, " R8"}, $sformatf("all_done k=%0d", k), adone, k == t);
      if (k == disturb_k) begin
        start = 1'b1;
        rates[s*8 +: 8] = 8'd128;
        lane = 2'd2;
        nbytes = 16'd9;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    rates[s*8 +: 8] = 8'(field);
    chk(adone == 1'b0 && busy == 1'b0, {req, " R8"}, "after end", adone, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cpol = 8'b1010_0110;
    cpha = 8'b0110_1100;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && launch == 0 && capture == 0, "R1", "strobes in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bcount == 0, "R1", "count after reset", bcount, 0);
    chk(bdone == 0 && adone == 0, "R1", "done after reset", adone, 0);
    for (int s = 0; s < ND; s++) begin
      sel = 3'(s);
      #1;
      chk(sck == cpol[s], "R1", $sformatf("idle sck sel=%0d", s), sck, cpol[s]);
    end

    // R2 fastest and slowest rates
    run_xfer("R2", 0, 128, 0, 3, -1);
    run_xfer("R2", 1, 1, 2, 1, -1);
    // R3 zero and non-power-of-two fields
    run_xfer("R3", 2, 0, 2, 1, -1);
    run_xfer("R3", 3, 6, 2, 1, -1);
    // R6 each lane code, including the reserved one
    run_xfer("R6", 4, 64, 1, 2, -1);
    run_xfer("R6", 5, 64, 3, 2, -1);
    // R8 zero-size transaction
    run_xfer("R8", 6, 32, 0, 0, -1);
    // R9 restart and field changes while busy
    run_xfer("R9", 7, 32, 0, 2, 40);
    run_xfer("R9", 1, 16, 1, 2, 70);

    // R10 random device select, rate, polarity, phase, lane, size
    for (int i = 0; i < 25; i++) begin
      int s, f, m, n;
      s = $urandom_range(0, ND - 1);
      f = 1 << $urandom_range(3, 7);
      m = $urandom_range(0, 3);
      n = $urandom_range(0, 4);
      cpol[s] = 1'($urandom_range(0, 1));
      cpha[s] = 1'($urandom_range(0, 1));
      run_xfer("R10", s, f, m, n, -1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule